// File: doc/BRIEF.md
# Byte-Serial Master with Select-Loss Fault Guard

This block is a byte-wide serial master for a synchronous four-wire bus. It makes the serial clock by dividing the system clock with a 3-bit rate code. It drives one byte out on the data-out pin and assembles one byte from the data-in pin. Clock polarity, clock phase and bit order can each be set. A start strobe with a transmit byte launches a transfer. A one-cycle done strobe marks the moment the received byte is valid.

Two control bits must both be written high before any transfer can start: a master-mode bit and an enable bit. The block also watches its own select input. That input comes either from an external pin or from an internal bit set by software, and a mode bit picks which one is used. If the chosen select goes low while either control bit is set, the block clears both bits and stops any transfer in progress. It then parks the clock at its idle level and raises a sticky fault flag. The flag stays set until a clear input is pulsed.

Top module: `spim_core`

## Requirements
- R1: After reset, sck, mosi, busy, done, fault, master and enable are 0, and rx_byte is 0x00.
- R2: The rate code `baud_sel` is captured when a start is accepted. The first sck toggle comes 2^baud_sel system clocks after the accepting edge, and each later toggle follows 2^baud_sel clocks after the one before. Every byte uses exactly 16 toggles (8 sck cycles).
- R3: While no transfer is running, sck sits at the `cpol` level. It follows that input with one cycle of latency.
- R4: In the cycle after the start is accepted, mosi shows the first bit: bit 7 when `lsb_first`=0, bit 0 when `lsb_first`=1. With `cpha`=0 the next bit appears on each trailing sck toggle. With `cpha`=1 it appears on each leading toggle except the first. mosi is 0 when idle.
- R5: miso is sampled on the leading toggles when `cpha`=0 and on the trailing toggles when `cpha`=1. The first sampled bit lands in bit 7 of rx_byte when `lsb_first`=0 and in bit 0 when `lsb_first`=1.
- R6: In the cycle after the 16th toggle, done is high for exactly one cycle, busy is low, and rx_byte holds the new byte. rx_byte changes at no other time.
- R7: A start is accepted only when master and enable are both 1, busy is 0 and the select is high. Any other start has no effect. This includes a start that arrives during a transfer.
- R8: The effective select is `sel_int` when `sel_soft`=1 and `sel_pin` when `sel_soft`=0. While it is low, master and enable read 0 from the next cycle on, and `cfg_wr` has no effect.
- R9: If the effective select is low while master or enable is 1, then from the next cycle fault is 1, busy is 0, sck is at `cpol`, and no done pulse is produced. This holds even when the 16th toggle falls in the same cycle.
- R10: fault stays set until `fault_clr` is pulsed. If `fault_clr` is high in the same cycle as a new fault, fault stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the master and enable bits |
| cfg_master | input | 1 | Master-mode value to write |
| cfg_enable | input | 1 | Enable value to write |
| baud_sel | input | 3 | Rate code; sck half-period is 2^code clocks |
| cpol | input | 1 | Idle level of sck |
| cpha | input | 1 | 0: sample on leading toggle; 1: sample on trailing toggle |
| lsb_first | input | 1 | 1: least significant bit first |
| sel_soft | input | 1 | 1: select taken from sel_int; 0: from sel_pin |
| sel_int | input | 1 | Software-managed select bit |
| sel_pin | input | 1 | Select pin input |
| fault_clr | input | 1 | Clears the sticky fault flag |
| start | input | 1 | Start strobe |
| tx_byte | input | 8 | Byte to send, captured with start |
| miso | input | 1 | Serial data in |
| rx_byte | output | 8 | Last received byte |
| done | output | 1 | One-cycle strobe for a completed byte |
| busy | output | 1 | Transfer in progress |
| master | output | 1 | Master-mode bit |
| enable | output | 1 | Enable bit |
| fault | output | 1 | Sticky select-loss fault |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |

## Verification
A loss of select can land in the same system clock as the 16th sck toggle, which would otherwise finish the byte. The bench drops the select pin in the negative half-cycle just before that toggle's edge. It expects the abort to win: no done pulse and no change to rx_byte. It also raises `fault_clr` in the same cycle as a fresh select loss and expects the flag to stay set. A behavioural model that runs one cycle at a time judges both cases on every clock.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned SPIM_DATA_W = 8;
  localparam int unsigned SPIM_BAUD_W = 3;

  typedef struct packed {
    logic cpha;
    logic lsb_first;
  } spim_fmt_t;
endpackage

// File: rtl/spim_ctl.sv
module spim_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_soft,
  input  logic sel_int,
  input  logic sel_pin,
  input  logic cfg_wr,
  input  logic cfg_master,
  input  logic cfg_enable,
  input  logic fault_clr,
  output logic master,
  output logic enable,
  output logic fault,
  output logic sel_eff,
  output logic abort
);
  logic master_q, enable_q, fault_q;
  logic ctl_en, master_d, enable_d;
  logic fault_en, fault_d;

  always_comb begin
    sel_eff  = sel_soft ? sel_int : sel_pin;
    abort    = ~sel_eff & (master_q | enable_q);
    ctl_en   = ~sel_eff | cfg_wr;
    master_d = sel_eff & cfg_master;
    enable_d = sel_eff & cfg_enable;
    fault_en = abort | fault_clr;
    fault_d  = abort;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      enable_q <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      if (ctl_en) begin
        master_q <= master_d;
        enable_q <= enable_d;
      end
      if (fault_en) fault_q <= fault_d;
    end
  end

  assign master = master_q;
  assign enable = enable_q;
  assign fault  = fault_q;
endmodule

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
  parameter int unsigned BAUD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [BAUD_W-1:0] baud,
  output logic              tick
);
  localparam int unsigned CNT_W = (1 << BAUD_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, term;

  always_comb begin
    term  = ~({CNT_W{1'b1}} << baud);
    tick  = run & (cnt_q == term);
    cnt_d = (tick | ~run) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BAUD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              abort,
  input  logic              tick,
  input  logic              cpol,
  input  spim_fmt_t         fmt_in,
  input  logic [BAUD_W-1:0] baud_in,
  input  logic [DATA_W-1:0] tx,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sck,
  output logic              mosi,
  output logic [BAUD_W-1:0] baud_q
);
  localparam int unsigned EDGES = 2 * DATA_W;
  localparam int unsigned K_W   = $clog2(EDGES);
  localparam logic [K_W-1:0] LAST_K = K_W'(EDGES - 1);

  logic              busy_q, busy_d, done_q, done_d, sck_q, sck_d, sck_en;
  logic [K_W-1:0]    k_q, k_d;
  logic              k_en;
  logic [DATA_W-1:0] sh_q, sh_d, rsh_q, rsh_d, rx_q, rx_d;
  logic              sh_en, rsh_en, rx_en;
  logic              samp, shft, last;
  spim_fmt_t         fmt_q;
  logic [BAUD_W-1:0] baud_r;

  always_comb begin
    samp   = tick & (k_q[0] == fmt_q.cpha);
    shft   = tick & (k_q[0] != fmt_q.cpha) & (k_q != '0);
    last   = tick & (k_q == LAST_K);
    if (abort)     busy_d = 1'b0;
    else if (go)   busy_d = 1'b1;
    else if (last) busy_d = 1'b0;
    else           busy_d = busy_q;
    done_d = last & ~abort;
    sck_en = ~busy_q | abort | tick;
    sck_d  = (~busy_q | abort) ? cpol : ~sck_q;
    k_en   = go | tick;
    k_d    = go ? '0 : k_q + 1'b1;
    sh_en  = go | shft;
    if (go)                   sh_d = tx;
    else if (fmt_q.lsb_first) sh_d = sh_q >> 1;
    else                      sh_d = sh_q << 1;
    rsh_en = samp & ~abort;
    rsh_d  = fmt_q.lsb_first ? {miso, rsh_q[DATA_W-1:1]} : {rsh_q[DATA_W-2:0], miso};
    rx_en  = last & ~abort;
    rx_d   = samp ? rsh_d : rsh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      k_q    <= '0;
      sh_q   <= '0;
      rsh_q  <= '0;
      rx_q   <= '0;
      fmt_q  <= '0;
      baud_r <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (sck_en) sck_q <= sck_d;
      if (k_en)   k_q   <= k_d;
      if (sh_en)  sh_q  <= sh_d;
      if (rsh_en) rsh_q <= rsh_d;
      if (rx_en)  rx_q  <= rx_d;
      if (go) begin
        fmt_q  <= fmt_in;
        baud_r <= baud_in;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign sck     = sck_q;
  assign mosi    = busy_q & (fmt_q.lsb_first ? sh_q[0] : sh_q[DATA_W-1]);
  assign baud_q  = baud_r;
endmodule

// File: rtl/spim_core.sv
module spim_core
  import spim_pkg::*;
#(
  parameter int unsigned DATA_W = SPIM_DATA_W,
  parameter int unsigned BAUD_W = SPIM_BAUD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_master,
  input  logic              cfg_enable,
  input  logic [BAUD_W-1:0] baud_sel,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              sel_soft,
  input  logic              sel_int,
  input  logic              sel_pin,
  input  logic              fault_clr,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              miso,
  output logic [DATA_W-1:0] rx_byte,
  output logic              done,
  output logic              busy,
  output logic              master,
  output logic              enable,
  output logic              fault,
  output logic              sck,
  output logic              mosi
);
  logic [1:0]        rst_sync_q;
  logic              rst_q_n;
  logic              sel_eff, abort, go, tick;
  logic [BAUD_W-1:0] baud_q;
  spim_fmt_t         fmt_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  assign fmt_in = '{cpha: cpha, lsb_first: lsb_first};
  assign go     = start & master & enable & ~busy & sel_eff;

  spim_ctl u_ctl (
    .clk(clk), .rst_n(rst_q_n), .sel_soft(sel_soft), .sel_int(sel_int),
    .sel_pin(sel_pin), .cfg_wr(cfg_wr), .cfg_master(cfg_master),
    .cfg_enable(cfg_enable), .fault_clr(fault_clr), .master(master),
    .enable(enable), .fault(fault), .sel_eff(sel_eff), .abort(abort)
  );

  spim_clkgen #(.BAUD_W(BAUD_W)) u_clkgen (
    .clk(clk), .rst_n(rst_q_n), .run(busy), .baud(baud_q), .tick(tick)
  );

  spim_shifter #(.DATA_W(DATA_W), .BAUD_W(BAUD_W)) u_shift (
    .clk(clk), .rst_n(rst_q_n), .go(go), .abort(abort), .tick(tick),
    .cpol(cpol), .fmt_in(fmt_in), .baud_in(baud_sel), .tx(tx_byte),
    .miso(miso), .busy(busy), .done(done), .rx_byte(rx_byte), .sck(sck),
    .mosi(mosi), .baud_q(baud_q)
  );
endmodule

// File: rtl/spim_core_chk.sv
module spim_core_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_soft,
  input logic sel_int,
  input logic sel_pin,
  input logic cpol,
  input logic fault_clr,
  input logic master,
  input logic enable,
  input logic fault,
  input logic busy,
  input logic done,
  input logic sck
);
  logic sel_chk;
  assign sel_chk = sel_soft ? sel_int : sel_pin;

  assert_idle_sck_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (busy || sck == $past(cpol)));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_start_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((!master || !enable) && !busy) |=> !busy);

  assert_sel_low_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_chk |=> (!master && !enable));

  assert_fault_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sel_chk && (master || enable)) |=> (!busy && !done && fault));

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_clr) |=> fault);

  assert_fault_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_chk && (master || enable)) |=> fault);
endmodule

bind spim_core spim_core_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .sel_soft(sel_soft), .sel_int(sel_int),
  .sel_pin(sel_pin), .cpol(cpol), .fault_clr(fault_clr), .master(master),
  .enable(enable), .fault(fault), .busy(busy), .done(done), .sck(sck)
);

// File: tb/spim_core_test.sv
`timescale 1ns/1ps
module spim_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_master = 0, cfg_enable = 0;
  logic [2:0] baud_sel = '0;
  logic cpol = 0, cpha = 0, lsb_first = 0;
  logic sel_soft = 0, sel_int = 0, sel_pin = 0, fault_clr = 0, start = 0;
  logic [7:0] tx_byte = '0;
  logic miso = 0;
  logic [7:0] rx_byte;
  logic done, busy, master, enable, fault, sck, mosi;

  always #4 clk = ~clk;

  spim_core uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_master(cfg_master),
    .cfg_enable(cfg_enable), .baud_sel(baud_sel), .cpol(cpol), .cpha(cpha),
    .lsb_first(lsb_first), .sel_soft(sel_soft), .sel_int(sel_int),
    .sel_pin(sel_pin), .fault_clr(fault_clr), .start(start),
    .tx_byte(tx_byte), .miso(miso), .rx_byte(rx_byte), .done(done),
    .busy(busy), .master(master), .enable(enable), .fault(fault),
    .sck(sck), .mosi(mosi)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  // behavioural reference state
  bit m_mst, m_en, m_fault, m_busy, m_done, m_sck, m_cpha, m_lsb;
  logic [7:0] m_rx, m_sh, m_rsh;
  int m_k, m_cnt, m_hp;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mst = 0; m_en = 0; m_fault = 0; m_busy = 0; m_done = 0; m_sck = 0;
      m_rx = 0; m_sh = 0; m_rsh = 0; m_k = 0; m_cnt = 0; m_hp = 1;
      m_cpha = 0; m_lsb = 0;
    end else begin
      bit sel, ev, go;
      sel = sel_soft ? sel_int : sel_pin;
      ev  = !sel && (m_mst || m_en);
      go  = start && m_mst && m_en && !m_busy && sel;
      m_done = 0;
      if (ev && m_busy) begin
        m_busy = 0; m_sck = cpol;
      end else if (m_busy) begin
        m_cnt++;
        if (m_cnt == m_hp) begin
          m_cnt = 0;
          m_sck = !m_sck;
          if ((m_k % 2) == m_cpha)
            m_rsh = m_lsb ? {miso, m_rsh[7:1]} : {m_rsh[6:0], miso};
          if ((m_k % 2) != m_cpha && m_k != 0)
            m_sh = m_lsb ? (m_sh >> 1) : (m_sh << 1);
          if (m_k == 15) begin
            m_busy = 0; m_done = 1; m_rx = m_rsh;
          end
          m_k++;
        end
      end else begin
        m_sck = cpol;
        if (go) begin
          m_busy = 1; m_cnt = 0; m_k = 0; m_hp = 1 << baud_sel;
          m_cpha = cpha; m_lsb = lsb_first; m_sh = tx_byte;
        end
      end
      if (ev) m_fault = 1;
      else if (fault_clr) m_fault = 0;
      if (!sel) begin m_mst = 0; m_en = 0; end
      else if (cfg_wr) begin m_mst = cfg_master; m_en = cfg_enable; end
    end
  end

  // per-cycle comparison and miso stimulus, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R2/R3 sck", {7'b0, sck}, {7'b0, m_sck});
      chk("R4 mosi", {7'b0, mosi}, {7'b0, m_busy ? (m_lsb ? m_sh[0] : m_sh[7]) : 1'b0});
      chk("R5 rx_byte", rx_byte, m_rx);
      chk("R6 done", {7'b0, done}, {7'b0, m_done});
      chk("R7/R9 busy", {7'b0, busy}, {7'b0, m_busy});
      chk("R8 master", {7'b0, master}, {7'b0, m_mst});
      chk("R8 enable", {7'b0, enable}, {7'b0, m_en});
      chk("R10 fault", {7'b0, fault}, {7'b0, m_fault});
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso = lfsr[0];
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d expected below 150000", cycles);
      finish_up();
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctl(input bit mst, input bit en);
    cfg_wr = 1; cfg_master = mst; cfg_enable = en;
    cyc(1);
    cfg_wr = 0;
  endtask

  task automatic xfer(input logic [7:0] b);
    start = 1; tx_byte = b;
    cyc(1);
    start = 0;
    while (m_busy) cyc(1);
    cyc(2);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(4);
    // R1 reset state
    chk("R1 outputs", {sck, mosi, busy, done, fault, master, enable, 1'b0}, 8'h00);
    chk("R1 rx_byte", rx_byte, 8'h00);

    // R7: start without master/enable is ignored
    sel_soft = 1; sel_int = 1;
    start = 1; tx_byte = 8'h3C; cyc(1); start = 0; cyc(3);
    chk("R7 busy without enable", {7'b0, busy}, 8'h00);
    write_ctl(1, 0);
    start = 1; cyc(1); start = 0; cyc(3);
    chk("R7 busy with enable low", {7'b0, busy}, 8'h00);
    write_ctl(1, 1);

    // R2..R6: all polarity/phase/order combinations and several rates
    for (int m = 0; m < 8; m++) begin
      cpol = m[0]; cpha = m[1]; lsb_first = m[2]; baud_sel = 3'(m % 4);
      cyc(2);
      xfer(8'hA5 ^ 8'(m * 37));
    end
    baud_sel = 3'd7; cpol = 1; cpha = 0; lsb_first = 0;
    xfer(8'h96);

    // R7: a second start during a transfer is ignored
    baud_sel = 3'd1; cpha = 1;
    start = 1; tx_byte = 8'hF0; cyc(1); start = 0;
    cyc(5);
    start = 1; tx_byte = 8'h0F; cyc(1); start = 0;
    while (m_busy) cyc(1);
    cyc(2);

    // R8: pin-managed select, normal byte then loss mid-transfer (R9)
    sel_soft = 0; sel_pin = 1; cyc(1);
    xfer(8'h5A);
    baud_sel = 3'd2;
    start = 1; tx_byte = 8'hC3; cyc(1); start = 0;
    cyc(20);
    sel_pin = 0; cyc(3);
    chk("R9 fault after select loss", {6'b0, fault, busy}, 8'h02);
    chk("R8 control cleared", {6'b0, master, enable}, 8'h00);
    write_ctl(1, 1); cyc(1);
    chk("R8 write ignored while select low", {6'b0, master, enable}, 8'h00);
    sel_pin = 1; fault_clr = 1; cyc(1); fault_clr = 0; cyc(1);
    chk("R10 fault cleared", {7'b0, fault}, 8'h00);

    // R9: select loss in the same cycle as the 16th toggle
    write_ctl(1, 1);
    baud_sel = 3'd0; cpha = 0;
    start = 1; tx_byte = 8'h81; cyc(1); start = 0;
    cyc(15);
    sel_pin = 0; cyc(1);
    chk("R9 no done on collision", {6'b0, done, busy}, 8'h00);
    chk("R9 fault on collision", {7'b0, fault}, 8'h01);
    cyc(2);

    // R10: clear and new fault in the same cycle
    sel_pin = 1; cyc(1);
    write_ctl(1, 1);
    sel_pin = 0; fault_clr = 1; cyc(1); fault_clr = 0;
    chk("R10 set wins over clear", {7'b0, fault}, 8'h01);
    sel_pin = 1; fault_clr = 1; cyc(1); fault_clr = 0; cyc(1);

    // R8: software select bit low with master set
    sel_soft = 1; sel_int = 1; write_ctl(1, 1);
    sel_int = 0; cyc(2);
    chk("R8 soft select loss", {5'b0, fault, master, enable}, 8'h04);
    sel_int = 1; fault_clr = 1; cyc(1); fault_clr = 0;
    write_ctl(1, 1);
    cpol = 0; lsb_first = 1; baud_sel = 3'd3;
    xfer(8'h6E);
    cyc(3);
    finish_up();
  end
endmodule